// File: doc/BRIEF.md
# Display Serial Command/Data Transmitter

This block is a write-only serial master that sends command and pixel-data bytes from the host side to a display controller. A client hands over one byte at a time on a valid/ready port. Each byte comes with a flag that says whether it is display data or a command. The block then drives four lines: an active-low chip select, a data-select line, a serial clock that idles low, and a serial data line. Bytes go out most significant bit first, and the receiver samples on the rising clock edge.

All timing is derived from the system clock period, `CLK_NS`, and three time limits given in nanoseconds. These limits are the minimum clock half-period, the chip-select lead before the first edge, and the chip-select trail after the last edge. Each limit is rounded up to a whole number of system cycles.

The byte and its flag are captured in the same cycle the request is accepted. The controller has five states, `ST_IDLE`, `ST_LEAD`, `ST_LOW`, `ST_HIGH` and `ST_TRAIL`, with these transitions:

- `ST_IDLE` goes to `ST_LEAD` when a request is accepted.
- `ST_LEAD` goes to `ST_LOW` when the lead time expires.
- `ST_LOW` goes to `ST_HIGH` when the low phase expires.
- `ST_HIGH` goes back to `ST_LOW` to shift the next bit, or to `ST_TRAIL` after the last bit.
- `ST_TRAIL` goes to `ST_IDLE` and releases chip select.
- `ST_TRAIL` instead goes straight to `ST_LOW`, loading a new byte with chip select still low, when a request is waiting as the trail time ends.

Top module: `disp_ser_tx`

## Requirements
- R1: After synchronous reset `rst`, `cs_n` is 1, `sclk` is 0 and `in_ready` is 1, with no transfer pending.
- R2: `sel_data` equals 1 for a byte accepted with `in_is_data`=1 and 0 for a byte accepted with `in_is_data`=0. It is stable while `sclk` is high, and it changes no sooner than 15 ns after a rising edge and no later than 15 ns before the rising edge of the last bit.
- R3: Each byte is shifted out MSB first: bit i of a byte (i = 7 down to 0) is on `sdo` at the (8-i)-th rising edge of `sclk`, and exactly 8 rising edges occur per byte.
- R4: Every rising edge of `sclk` happens while `cs_n` is 0, and `cs_n` is 1 whenever the block is idle.
- R5: `sclk` stays high for at least 50 ns and low for at least 50 ns in every phase.
- R6: `cs_n` falls at least 20 ns before the first rising edge of a byte, and rises no sooner than 50 ns after the last rising edge.
- R7: `sdo` does not change while `sclk` is high. Each change is at least 15 ns after the preceding rising edge and at least 15 ns before the next one.
- R8: Byte and flag are captured at acceptance. Later changes on `in_byte` or `in_is_data` do not alter the byte being sent.
- R9: `in_ready` is 1 only in `ST_IDLE` or in the last cycle of `ST_TRAIL`. It drops in the cycle after an acceptance. A request held during a transfer is delayed, not lost, and bytes go out in acceptance order.
- R10: When a request is waiting as `ST_TRAIL` ends, the next byte starts without `cs_n` returning high. A burst of back-to-back bytes therefore produces exactly one rising edge of `cs_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can accept a request this cycle |
| in_byte | input | BYTE_W | Byte to send |
| in_is_data | input | 1 | 1 = display data, 0 = command |
| cs_n | output | 1 | Chip select, active low |
| sel_data | output | 1 | Data/command select line to the receiver |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data out |

## Verification
On every cycle, the bound checker watches the local timing rules, counting cycles to do so. These rules are that chip select is low at each rising clock edge, that data and select lines stay still during the high phase, and that each clock phase and both chip-select windows are long enough. It also checks that ready falls after each acceptance.

Some behaviour can only be shown by the bench scenarios, which compare against a queue of accepted items. These are the MSB-first order and the content of whole bytes, and the flag captured at acceptance even when the inputs change afterwards. They also cover requests held off mid-byte that still arrive in order, and the single chip-select release across a burst.

// File: rtl/disp_ser_pkg.sv
package disp_ser_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH,
        ST_TRAIL
    } tx_state_e;

    // Whole system cycles needed to cover a time in ns (at least one).
    function automatic int cyc_for_ns(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/disp_ser_tick.sv
module disp_ser_tick #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= len - CNT_W'(1);
        else if (cnt != '0)
            cnt <= cnt - CNT_W'(1);
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/disp_ser_shift.sv
module disp_ser_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              load_flag,
    input  logic              shift,
    output logic              sdo,
    output logic              flag,
    output logic              last
);
    localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

    logic [BYTE_W-1:0] data;
    logic [IDX_W-1:0]  idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
            flag <= 1'b0;
            idx  <= '0;
        end else if (load) begin
            data <= load_byte;
            flag <= load_flag;
            idx  <= '0;
        end else if (shift) begin
            data <= {data[BYTE_W-2:0], 1'b0};
            idx  <= idx + IDX_W'(1);
        end
    end

    assign sdo  = data[BYTE_W-1];
    assign last = (idx == IDX_W'(BYTE_W - 1));
endmodule

// File: rtl/disp_ser_tx.sv
module disp_ser_tx
    import disp_ser_pkg::*;
#(
    parameter int CLK_NS      = 20,
    parameter int BYTE_W      = 8,
    parameter int SCK_HALF_NS = 50,
    parameter int CS_LEAD_NS  = 20,
    parameter int CS_TRAIL_NS = 50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_is_data,
    output logic              cs_n,
    output logic              sel_data,
    output logic              sclk,
    output logic              sdo
);
    localparam int HALF_CYC  = cyc_for_ns(SCK_HALF_NS, CLK_NS);
    localparam int LEAD_CYC  = cyc_for_ns(CS_LEAD_NS, CLK_NS);
    localparam int TRAIL_CYC = cyc_for_ns(CS_TRAIL_NS, CLK_NS);
    localparam int MAX_A     = (HALF_CYC > LEAD_CYC) ? HALF_CYC : LEAD_CYC;
    localparam int MAX_CYC   = (MAX_A > TRAIL_CYC) ? MAX_A : TRAIL_CYC;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    tx_state_e        state, nxt;
    logic             t_start, t_done;
    logic [CNT_W-1:0] t_len;
    logic             sh_load, sh_shift, sh_last;

    disp_ser_tick #(.CNT_W(CNT_W)) u_tick (
        .clk   (clk),
        .rst   (rst),
        .start (t_start),
        .len   (t_len),
        .done  (t_done)
    );

    disp_ser_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (sh_load),
        .load_byte (in_byte),
        .load_flag (in_is_data),
        .shift     (sh_shift),
        .sdo       (sdo),
        .flag      (sel_data),
        .last      (sh_last)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt      = state;
        t_start  = 1'b0;
        t_len    = CNT_W'(HALF_CYC);
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (state)
            ST_IDLE: if (in_valid) begin
                nxt     = ST_LEAD;
                t_start = 1'b1;
                t_len   = CNT_W'(LEAD_CYC);
                sh_load = 1'b1;
            end
            ST_LEAD: if (t_done) begin
                nxt     = ST_LOW;
                t_start = 1'b1;
            end
            ST_LOW: if (t_done) begin
                nxt     = ST_HIGH;
                t_start = 1'b1;
            end
            ST_HIGH: if (t_done) begin
                t_start = 1'b1;
                if (sh_last) begin
                    nxt   = ST_TRAIL;
                    t_len = CNT_W'(TRAIL_CYC);
                end else begin
                    nxt      = ST_LOW;
                    sh_shift = 1'b1;
                end
            end
            ST_TRAIL: if (t_done) begin
                if (in_valid) begin
                    nxt     = ST_LOW;
                    t_start = 1'b1;
                    sh_load = 1'b1;
                end else begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cs_n     = (state == ST_IDLE);
        sclk     = (state == ST_HIGH);
        in_ready = (state == ST_IDLE) || ((state == ST_TRAIL) && t_done);
    end
endmodule

// File: rtl/disp_ser_tx_chk.sv
module disp_ser_tx_chk
    import disp_ser_pkg::*;
#(
    parameter int CLK_NS      = 20,
    parameter int SCK_HALF_NS = 50,
    parameter int CS_LEAD_NS  = 20,
    parameter int CS_TRAIL_NS = 50
) (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_ready,
    input logic cs_n,
    input logic sel_data,
    input logic sclk,
    input logic sdo
);
    localparam int HALF_CYC  = cyc_for_ns(SCK_HALF_NS, CLK_NS);
    localparam int LEAD_CYC  = cyc_for_ns(CS_LEAD_NS, CLK_NS);
    localparam int TRAIL_CYC = cyc_for_ns(CS_TRAIL_NS, CLK_NS);

    logic        sclk_q, cs_q;
    logic [15:0] run, rise_age, cs_age;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q   <= 1'b0;
            cs_q     <= 1'b1;
            run      <= '0;
            rise_age <= '0;
            cs_age   <= '0;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs_n;
            if (sclk != sclk_q)          run <= 16'd1;
            else if (run != 16'hFFFF)    run <= run + 16'd1;
            if (sclk && !sclk_q)         rise_age <= 16'd1;
            else if (rise_age != 16'hFFFF) rise_age <= rise_age + 16'd1;
            if (!cs_n && cs_q)           cs_age <= 16'd1;
            else if (cs_age != 16'hFFFF) cs_age <= cs_age + 16'd1;
        end
    end

    // R4
    edge_cs_low_chk: assert property (@(posedge clk) disable iff (rst)
        sclk |-> !cs_n);
    // R7
    sdo_still_chk: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(sdo));
    // R2
    sel_still_chk: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(sel_data));
    // R9
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);
    // R9
    ready_clk_low_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> !sclk);
    // R5
    high_width_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk_q && !sclk) |-> (run >= 16'(HALF_CYC)));
    // R5
    low_width_chk: assert property (@(posedge clk) disable iff (rst)
        (!sclk_q && sclk) |-> (run >= 16'(HALF_CYC)));
    // R6
    cs_lead_chk: assert property (@(posedge clk) disable iff (rst)
        (!sclk_q && sclk && !cs_q) |-> (cs_age >= 16'(LEAD_CYC)));
    // R6
    cs_trail_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_n && !cs_q) |-> (rise_age >= 16'(TRAIL_CYC)));
endmodule

bind disp_ser_tx disp_ser_tx_chk #(
    .CLK_NS(CLK_NS), .SCK_HALF_NS(SCK_HALF_NS),
    .CS_LEAD_NS(CS_LEAD_NS), .CS_TRAIL_NS(CS_TRAIL_NS)
) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .cs_n(cs_n), .sel_data(sel_data), .sclk(sclk), .sdo(sdo)
);

// File: tb/sim_disp_ser_tx.sv
`timescale 1ns/1ps
module sim_disp_ser_tx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_is_data = 1'b0;
    logic       in_ready, cs_n, sel_data, sclk, sdo;

    int n_total = 0;
    int n_bad   = 0;
    int n_sent  = 0;
    int n_rx    = 0;
    int cs_rises = 0;
    int nbits   = 0;
    logic [7:0] sh = 8'h00;
    logic [8:0] exp_q[$];
    realtime t_rise = 0, t_fall = 0, t_csfall = 0, t_sdo = 0, t_sel = 0;

    always #10 clk = ~clk;

    disp_ser_tx u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .in_is_data(in_is_data), .cs_n(cs_n),
        .sel_data(sel_data), .sclk(sclk), .sdo(sdo)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    endtask

    // Monitor: rebuild bytes on rising sclk, compare against the scoreboard
    always @(posedge sclk) if (!rst) begin
        logic [8:0] e;
        chk(cs_n == 1'b0, "R4 cs_n at rising edge", int'(cs_n), 0);
        chk(($realtime - t_fall) >= 50.0, "R5 low phase ns", int'($realtime - t_fall), 50);
        chk(($realtime - t_sdo) >= 15.0, "R7 sdo setup ns", int'($realtime - t_sdo), 15);
        if (nbits == 0)
            chk(($realtime - t_csfall) >= 20.0, "R6 cs lead ns", int'($realtime - t_csfall), 20);
        sh = {sh[6:0], sdo};
        nbits++;
        t_rise = $realtime;
        if (nbits == 8) begin
            nbits = 0;
            n_rx++;
            chk(($realtime - t_sel) >= 15.0, "R2 sel setup ns", int'($realtime - t_sel), 15);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected byte", int'(sh), -1);
            end else begin
                e = exp_q.pop_front();
                chk(sh == e[7:0], "R3 byte MSB first", int'(sh), int'(e[7:0]));
                chk(sel_data == e[8], "R2 sel_data flag", int'(sel_data), int'(e[8]));
            end
        end
    end

    always @(negedge sclk) if (!rst) begin
        chk(($realtime - t_rise) >= 50.0, "R5 high phase ns", int'($realtime - t_rise), 50);
        t_fall = $realtime;
    end

    always @(posedge cs_n) if (!rst) begin
        chk(($realtime - t_rise) >= 50.0, "R6 cs trail ns", int'($realtime - t_rise), 50);
        chk(nbits == 0, "R3 whole bytes only", nbits, 0);
        cs_rises++;
    end

    always @(negedge cs_n) t_csfall = $realtime;

    always @(sdo) begin
        if (!rst)
            chk(($realtime - t_rise) >= 15.0, "R7 sdo hold ns", int'($realtime - t_rise), 15);
        t_sdo = $realtime;
    end

    always @(sel_data) begin
        if (!rst)
            chk(($realtime - t_rise) >= 15.0, "R2 sel hold ns", int'($realtime - t_rise), 15);
        t_sel = $realtime;
    end

    // Driver: present a request, record it when accepted, then scramble inputs (R8)
    task automatic send(input logic [7:0] b, input logic d, input bit expect_busy);
        @(negedge clk);
        in_valid   = 1'b1;
        in_byte    = b;
        in_is_data = d;
        if (expect_busy)
            chk(!in_ready && !cs_n, "R9 held off while busy", int'(in_ready), 0);
        while (!in_ready) @(negedge clk);
        exp_q.push_back({d, b});
        n_sent++;
        @(negedge clk);
        in_valid   = 1'b0;
        in_byte    = ~b;
        in_is_data = ~d;
        chk(!in_ready, "R9 ready drops after accept", int'(in_ready), 0);
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0 || !cs_n) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R4 cs_n high when idle", int'(cs_n), 1);
    endtask

    initial begin
        #3000000;
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int r0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n == 1'b1, "R1 cs_n after reset", int'(cs_n), 1);
        chk(sclk == 1'b0, "R1 sclk after reset", int'(sclk), 0);
        chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);

        // Single bytes, command and data, with idle gaps
        send(8'hAE, 1'b0, 1'b0); wait_idle();
        send(8'hFF, 1'b1, 1'b0); wait_idle();
        send(8'h00, 1'b1, 1'b0); wait_idle();
        // R8: inputs change right after accept
        send(8'h5A, 1'b0, 1'b0); wait_idle();
        send(8'h81, 1'b1, 1'b0); wait_idle();

        // R9: request arriving mid-byte is held off, then sent in order
        send(8'hA5, 1'b0, 1'b0);
        repeat (7) @(negedge clk);
        send(8'h3C, 1'b1, 1'b1);
        wait_idle();

        // R10: back-to-back burst keeps cs_n low between bytes
        r0 = cs_rises;
        send(8'hA1, 1'b0, 1'b0);
        send(8'hC8, 1'b0, 1'b1);
        send(8'h12, 1'b1, 1'b1);
        send(8'hDF, 1'b1, 1'b1);
        wait_idle();
        chk((cs_rises - r0) == 1, "R10 single cs release in burst", cs_rises - r0, 1);

        chk(n_rx == n_sent, "R9 no request dropped", n_rx, n_sent);
        finish_run();
    end
endmodule